// File: doc/BRIEF.md
# Equalizer Settings Bus Slave

This block is a write-only two-wire serial bus slave that holds the settings of a five-band stereo tone equalizer. A bus master addresses the slave, sends one subaddress byte, and follows it with one or more data bytes. Each data byte lands in the band register that the current subaddress points to, and the subaddress then moves forward by one, so a single burst can load every band.

Each band register holds a boost code and a cut code. The block turns them into step numbers from 0 to 5 for an analog filter back end. A defeat flag in the first band register forces every effective step to zero but leaves the stored codes untouched. The SCL and SDA inputs are taken as already synchronized to the system clock. The block drives the bus only by pulling SDA low to acknowledge, and does so through an output enable.

Top module: `eqc_top`

## Requirements
- R1: The slave answers the address byte 0x84 when `addr_sel_i` is 0, and 0x86 when `addr_sel_i` is 1. Bit 0 of the address byte is the read/write bit and must be 0. Any other address byte, including one with the read bit set, gets no acknowledge.
- R2: The slave acknowledges a matched address byte, every subaddress byte and every data byte by raising `sda_oe_o` during the ninth clock. `sda_oe_o` changes only while SCL is low.
- R3: Subaddress k, for k from 0 to 4, writes band k. In each band, bits 6:4 hold the boost code and bits 2:0 hold the cut code. Bit 3 is stored as 0. Bit 7 is kept only in band 0, where it is the defeat flag; in bands 1 to 4 it is stored as 0.
- R4: After each data byte the subaddress advances by one, so consecutive data bytes in one burst fill consecutive bands.
- R5: Codes 0 to 4 give that step. Codes 5, 6 and 7 all give step 5. `boost_o` and `cut_o` carry band k in bits 3k+2:3k.
- R6: While defeat is 1, every field of `boost_o` and `cut_o` is 0. Stored codes reappear unchanged when defeat is cleared.
- R7: After reset, defeat is 1, all stored codes are 0, `sda_oe_o` is 0 and the receiver is idle.
- R8: A subaddress from 5 to 255 is acknowledged, but data written to it is discarded. The pointer saturates at 7 and never wraps back to band 0.
- R9: After a non-matching address byte, the slave acknowledges nothing and writes nothing until the next start condition.
- R10: A stop or a repeated start in the middle of a byte abandons that byte without any register write. A transfer that follows a repeated start works normally.
- R11: Settings outputs change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired-AND of master and slave) |
| addr_sel_i | input | 1 | Selects which of the two slave addresses is answered |
| sda_oe_o | output | 1 | When 1, the slave pulls SDA low |
| defeat_o | output | 1 | Defeat flag (band 0, bit 7) |
| boost_o | output | 15 | Effective boost step per band, 3 bits each |
| cut_o | output | 15 | Effective cut step per band, 3 bits each |

## Verification
The bench builds the block with its defaults: five bands and a 3-bit subaddress pointer. With these values, the discarded subaddresses 5 to 7 and the saturation at 7 are reachable with bursts only a few bytes long. Every raw code from 0 to 7 is reachable in both fields, so all three saturating codes are exercised. The bench also runs the no-wrap case after a long burst, address rejection for both select levels and for the read bit, and abandoned partial bytes under both stop and repeated start.

// File: rtl/eqc_pkg.sv
// Shared types and helpers for the equalizer settings slave.
package eqc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_ACK  = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        BK_ADDR = 2'd0,
        BK_SUB  = 2'd1,
        BK_DATA = 2'd2
    } kind_t;

    localparam int CODE_W    = 3;
    localparam int BOOST_LSB = 4;
    localparam int CUT_LSB   = 0;
    localparam int FLAG_BIT  = 7;
    localparam logic [CODE_W-1:0] TOP_STEP = 3'd5;

    // Clamp a raw 3-bit code to the highest step.
    function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c);
        return (c > TOP_STEP) ? TOP_STEP : c;
    endfunction

endpackage

// File: rtl/eqc_line_watch.sv
// Line watcher: samples the already-synchronized SCL/SDA once more and
// reports clock edges plus start and stop conditions.
// Assumes each SCL level lasts at least two system clocks.
module eqc_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic s_scl, p_scl, s_sda, p_sda;

    // Two-deep history of both lines, idle-high at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_scl <= 1'b1;
            p_scl <= 1'b1;
            s_sda <= 1'b1;
            p_sda <= 1'b1;
        end else begin
            s_scl <= scl_i;
            p_scl <= s_scl;
            s_sda <= sda_i;
            p_sda <= s_sda;
        end
    end

    // Edge and condition decode; SCL must be high in both samples for start/stop.
    always_comb begin
        scl_rise  = s_scl & ~p_scl;
        scl_fall  = ~s_scl & p_scl;
        start_det = s_scl & p_scl & ~s_sda & p_sda;
        stop_det  = s_scl & p_scl & s_sda & ~p_sda;
        sda_bit   = s_sda;
    end
endmodule

// File: rtl/eqc_byte_engine.sv
// Byte engine: shifts in bytes, matches the slave address, drives the
// acknowledge and issues one-cycle strobes for subaddress and data bytes.
// Assumes write-only traffic; partial bytes are dropped on start/stop.
module eqc_byte_engine #(
    parameter logic [7:0] ADDR_LO = 8'h84,
    parameter logic [7:0] ADDR_HI = 8'h86
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_bit,
    input  logic       addr_sel,
    output logic       sda_oe,
    output logic       sub_load,
    output logic       data_wr,
    output logic [7:0] byte_val
);
    import eqc_pkg::*;

    localparam int BITS = 8;
    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

    phase_t           phase;
    kind_t            kind;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg;
    logic             byte_done;
    logic [7:0]       my_addr;

    // Completion of a received byte at the falling clock after bit eight.
    always_comb begin
        my_addr   = addr_sel ? ADDR_HI : ADDR_LO;
        byte_done = (phase == PH_RECV) && scl_fall && (cnt == FULL)
                    && !start_det && !stop_det;
        sub_load  = byte_done && (kind == BK_SUB);
        data_wr   = byte_done && (kind == BK_DATA);
        byte_val  = shreg;
    end

    // Receive/acknowledge sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            kind   <= BK_ADDR;
            cnt    <= '0;
            shreg  <= '0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            phase  <= PH_RECV;
            kind   <= BK_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (phase)
                PH_RECV: begin
                    if (scl_rise && cnt != FULL) begin
                        shreg <= {shreg[6:0], sda_bit};
                        cnt   <= cnt + 1'b1;
                    end
                    if (byte_done) begin
                        if (kind == BK_ADDR && shreg != my_addr) begin
                            phase <= PH_SKIP;
                        end else begin
                            phase  <= PH_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_RECV;
                        cnt    <= '0;
                        kind   <= (kind == BK_ADDR) ? BK_SUB : BK_DATA;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eqc_band_bank.sv
// Band bank: subaddress pointer with saturating auto-increment and the
// band registers. Assumes strobes last one cycle each.
module eqc_band_bank #(
    parameter int NBANDS = 5,
    parameter int PTR_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sub_load,
    input  logic                         data_wr,
    input  logic [7:0]                   byte_val,
    output logic [NBANDS*8-1:0]          bands_flat
);
    localparam logic [PTR_W-1:0] PTR_TOP = '1;
    localparam logic [7:0]       TOP_8   = 8'(PTR_TOP);
    localparam logic [7:0]       KEEP_0  = 8'hF7;
    localparam logic [7:0]       KEEP_N  = 8'h77;

    logic [PTR_W-1:0] ptr;

    // Pointer load on subaddress, saturating advance after each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (sub_load) begin
            ptr <= (byte_val > TOP_8) ? PTR_TOP : byte_val[PTR_W-1:0];
        end else if (data_wr && ptr != PTR_TOP) begin
            ptr <= ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < NBANDS; i++) begin : g_band
        localparam logic [7:0] KEEP = (i == 0) ? KEEP_0 : KEEP_N;
        localparam logic [7:0] INIT = (i == 0) ? 8'h80 : 8'h00;
        logic [7:0] r;
        // Store the masked data byte when the pointer selects this band.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= INIT;
            end else if (data_wr && ptr == PTR_W'(i)) begin
                r <= byte_val & KEEP;
            end
        end
        assign bands_flat[i*8 +: 8] = r;
    end
endmodule

// File: rtl/eqc_gain_out.sv
// Gain output stage: clamps stored codes to steps and zeroes them while
// defeat is set. Purely combinational.
module eqc_gain_out #(
    parameter int NBANDS = 5
) (
    input  logic [NBANDS*8-1:0] bands_flat,
    output logic                defeat,
    output logic [NBANDS*3-1:0] boost,
    output logic [NBANDS*3-1:0] cut
);
    import eqc_pkg::*;

    assign defeat = bands_flat[FLAG_BIT];

    for (genvar i = 0; i < NBANDS; i++) begin : g_step
        // Per-band clamp and defeat mask.
        always_comb begin
            boost[i*3 +: 3] = defeat ? 3'd0 : sat_code(bands_flat[i*8 + BOOST_LSB +: CODE_W]);
            cut[i*3 +: 3]   = defeat ? 3'd0 : sat_code(bands_flat[i*8 + CUT_LSB +: CODE_W]);
        end
    end
endmodule

// File: rtl/eqc_top.sv
// Equalizer settings slave top: line watcher, byte engine, band bank and
// gain output stage. Assumes SCL/SDA are synchronized to clk.
module eqc_top #(
    parameter int NBANDS = 5,
    parameter int PTR_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                addr_sel_i,
    output logic                sda_oe_o,
    output logic                defeat_o,
    output logic [NBANDS*3-1:0] boost_o,
    output logic [NBANDS*3-1:0] cut_o
);
    logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic sub_load, data_wr;
    logic [7:0] byte_val;
    logic [NBANDS*8-1:0] bands_flat;

    eqc_line_watch u_watch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
    );

    eqc_byte_engine u_eng (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
        .addr_sel(addr_sel_i), .sda_oe(sda_oe_o), .sub_load(sub_load),
        .data_wr(data_wr), .byte_val(byte_val)
    );

    eqc_band_bank #(.NBANDS(NBANDS), .PTR_W(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .sub_load(sub_load), .data_wr(data_wr),
        .byte_val(byte_val), .bands_flat(bands_flat)
    );

    eqc_gain_out #(.NBANDS(NBANDS)) u_gain (
        .bands_flat(bands_flat), .defeat(defeat_o), .boost(boost_o), .cut(cut_o)
    );
endmodule

// File: rtl/eqc_checker.sv
// Checker for the equalizer settings slave, bound to eqc_top.
module eqc_checker #(
    parameter int NBANDS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_i,
    input logic                sda_oe_o,
    input logic                defeat_o,
    input logic [NBANDS*3-1:0] boost_o,
    input logic [NBANDS*3-1:0] cut_o
);
    // R6: defeat masks every step
    a_r6_defeat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        defeat_o |-> (boost_o == '0 && cut_o == '0));

    // R2: acknowledge starts only while SCL is low
    a_r2_ack_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R2: acknowledge ends only while SCL is low
    a_r2_ack_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_i);

    // R2: acknowledge held through the high phase
    a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o && scl_i) |=> sda_oe_o);

    // R11: settings move only with SCL low
    a_r11_change_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({defeat_o, boost_o, cut_o}) |-> !scl_i);

    for (genvar g = 0; g < NBANDS; g++) begin : g_lim
        // R5: no step above the maximum
        a_r5_step_max: assert property (@(posedge clk) disable iff (!rst_n)
            (boost_o[g*3 +: 3] <= 3'd5) && (cut_o[g*3 +: 3] <= 3'd5));
    end
endmodule

bind eqc_top eqc_checker #(.NBANDS(NBANDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .defeat_o(defeat_o), .boost_o(boost_o), .cut_o(cut_o)
);

// File: tb/sim_eqc_top.sv
module sim_eqc_top;
    localparam int NB = 5;
    localparam int Q  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe, defeat;
    logic [NB*3-1:0] boost, cut;
    wire  sda_line = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] mdl [NB];

    always #4 clk = ~clk;

    eqc_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .defeat_o(defeat),
        .boost_o(boost), .cut_o(cut)
    );

    // R1..R10 table: {subaddress, data}, written one byte per transfer.
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        16'h00_00, 16'h01_12, 16'h02_35, 16'h03_47, 16'h04_76,
        16'h00_53, 16'h01_F1, 16'h02_0F, 16'h05_77, 16'h03_00
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] clamp(input logic [2:0] c);
        return (c > 3'd5) ? 3'd5 : c;
    endfunction

    task automatic mdl_write(input logic [7:0] sub, input logic [7:0] d);
        if (sub < NB) mdl[sub] = d & ((sub == 0) ? 8'hF7 : 8'h77);
    endtask

    task automatic check_all(input string req);
        logic [NB*3-1:0] eb, ec;
        logic dflt;
        dflt = mdl[0][7];
        for (int b = 0; b < NB; b++) begin
            eb[b*3 +: 3] = dflt ? 3'd0 : clamp(mdl[b][6:4]);
            ec[b*3 +: 3] = dflt ? 3'd0 : clamp(mdl[b][2:0]);
        end
        @(negedge clk);
        chk({req, " defeat"}, 32'(defeat), 32'(dflt));
        chk({req, " boost"}, 32'(boost), 32'(eb));
        chk({req, " cut"}, 32'(cut), 32'(ec));
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_sda = 1'b1; waitq(4 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int k = 7; k > 7 - n; k--) begin
            m_sda = b[k]; waitq(Q);
            m_scl = 1'b1; waitq(2 * Q);
            m_scl = 1'b0; waitq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        ack = sda_oe;
        waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic write1(input logic [7:0] adr, input logic [7:0] sub, input logic [7:0] d,
                          output logic [2:0] acks);
        bstart();
        send_byte(adr, acks[2]);
        send_byte(sub, acks[1]);
        send_byte(d, acks[0]);
        bstop();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic a;
        for (int b = 0; b < NB; b++) mdl[b] = 8'h00;
        mdl[0] = 8'h80;
        waitq(5);
        rst_n = 1'b1;
        waitq(2);
        // R7 reset state
        chk("R7 sda_oe", 32'(sda_oe), 0);
        check_all("R7 reset");

        // Table walk: R3 field placement, R5 clamp, R2 acks, R8 discard
        for (int v = 0; v < NV; v++) begin
            write1(8'h84, VEC[v][15:8], VEC[v][7:0], acks);
            chk("R2 acks", 32'(acks), 32'h7);
            mdl_write(VEC[v][15:8], VEC[v][7:0]);
            check_all("R3 R5 table");
        end

        // R4 burst from band 0, with defeat set: R6 outputs masked
        bstart();
        send_byte(8'h84, a);
        send_byte(8'h00, a);
        send_byte(8'h91, a); mdl_write(0, 8'h91);
        send_byte(8'h23, a); mdl_write(1, 8'h23);
        send_byte(8'h45, a); mdl_write(2, 8'h45);
        send_byte(8'h56, a); mdl_write(3, 8'h56);
        send_byte(8'h07, a); mdl_write(4, 8'h07);
        chk("R4 last ack", 32'(a), 1);
        bstop();
        check_all("R4 R6 burst defeated");
        // R6 clear defeat: stored bands 1..4 reappear unchanged
        write1(8'h84, 8'h00, 8'h13, acks);
        mdl_write(0, 8'h13);
        check_all("R6 restore");

        // R8 burst from band 3 past the end: no wrap into band 0
        bstart();
        send_byte(8'h84, a);
        send_byte(8'h03, a);
        send_byte(8'h61, a); mdl_write(3, 8'h61);
        send_byte(8'h16, a); mdl_write(4, 8'h16);
        for (int k = 0; k < 5; k++) begin
            send_byte(8'hFF, a);
            chk("R8 ack past end", 32'(a), 1);
        end
        bstop();
        check_all("R8 no wrap");

        // R8 high subaddress acknowledged and discarded
        write1(8'h84, 8'hC8, 8'h80, acks);
        chk("R8 high sub acks", 32'(acks), 32'h7);
        check_all("R8 high sub");

        // R1 R9 wrong address and read bit: NACK, nothing written
        write1(8'h88, 8'h00, 8'h80, acks);
        chk("R1 R9 wrong addr acks", 32'(acks), 0);
        check_all("R9 wrong addr");
        write1(8'h85, 8'h01, 8'h55, acks);
        chk("R1 read bit acks", 32'(acks), 0);
        check_all("R1 read bit");

        // R1 select high: 0x84 ignored, 0x86 answered
        addr_sel = 1'b1;
        write1(8'h84, 8'h01, 8'h55, acks);
        chk("R1 sel high old addr", 32'(acks), 0);
        check_all("R1 sel high old");
        write1(8'h86, 8'h01, 8'h55, acks);
        chk("R1 sel high new addr", 32'(acks), 32'h7);
        mdl_write(1, 8'h55);
        check_all("R1 sel high new");
        addr_sel = 1'b0;

        // R10 stop in the middle of a data byte
        bstart();
        send_byte(8'h84, a);
        send_byte(8'h01, a);
        send_bits(8'h33, 3);
        bstop();
        check_all("R10 mid stop");

        // R10 repeated start in the middle of a data byte, then a good write
        bstart();
        send_byte(8'h84, a);
        send_byte(8'h02, a);
        send_bits(8'h77, 5);
        bstart();
        send_byte(8'h84, a);
        chk("R10 addr ack after restart", 32'(a), 1);
        send_byte(8'h03, a);
        send_byte(8'h21, a);
        bstop();
        mdl_write(3, 8'h21);
        check_all("R10 restart");

        // R7 reset mid-life: defeat back, stored codes cleared
        rst_n = 1'b0; waitq(3); rst_n = 1'b1; waitq(2);
        for (int b = 0; b < NB; b++) mdl[b] = 8'h00;
        mdl[0] = 8'h80;
        check_all("R7 re-reset");
        write1(8'h84, 8'h00, 8'h00, acks);
        mdl_write(0, 8'h00);
        check_all("R7 cleared bands");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule